// File: doc/BRIEF.md
# LIN transmitter fault supervisor

This block guards the transmit path of several LIN transceiver channels. Each channel supplies five inputs: its local transmit input, the sampled bus level, a thermal shutdown flag, a supply undervoltage comparator and a 2-bit transceiver mode. The block detects a transmit input that stays dominant for too long and a bus that stays dominant for too long. While any fault is present it holds that channel's transmitter-enable output low. It raises the output again only after the recovery rule for the fault type has been met and the transmit input has then stayed high for a qualified enable time.

Each channel keeps a latched 2-bit fault code in a packed status word, together with a shared latched thermal flag. A one-cycle read strobe returns the word and then clears the codes and the thermal flag. A fault that is still present after the read is latched again on the following cycle. All timeouts are parameters counted in clock cycles.

Top module: `lin_tx_supervisor`

## Requirements
- R1: The status word holds channel 0's code at bits 2:1, channel 1's at bits 4:3 and channel 2's at bits 6:5. Bits 0 and 7 always read 0. After reset every code is 00, every `tx_en_o` bit is 1 and `tsd_flag_o` is 0.
- R2: The fault codes are: 00 no fault, 01 thermal shutdown, 10 transmit-input dominant timeout, 11 bus dominant timeout.
- R3: While the channel mode is normal (mode bit 1 = 1), a transmit input held low for TXD_TO_CYC consecutive clock edges sets the transmit timeout. From the next cycle `tx_en_o` is low, and one cycle later the code reads 10.
- R4: While the channel mode is normal, a bus level held low (dominant) for BUS_TO_CYC consecutive edges sets the bus timeout. From the next cycle `tx_en_o` is low, and one cycle later the code reads 11.
- R5: A high thermal input drives that channel's `tx_en_o` low in the same cycle. At the next edge the code 01 is latched and `tsd_flag_o` is set.
- R6: The transmit timeout clears when the transmit input goes high, or when the mode changes to wake-capable (01) or off (00).
- R7: The bus timeout clears when the bus goes high (recessive), or when the mode changes to wake-capable or off.
- R8: A high undervoltage input holds `tx_en_o` low for as long as it lasts and latches no code. Recovery begins as soon as the input falls.
- R9: Once no fault remains, `tx_en_o` rises only after the transmit input has been high for TXD_EN_CYC consecutive edges. Any low cycle restarts the count.
- R10: While `rd_i` is high, the status word shows the latched codes. The edge that samples `rd_i` clears them to 00. A fault still present is latched again at the following edge.
- R11: A nonzero code is held until it is read, even if other faults arrive. When several faults are present in the same cycle, the code chosen is 01 first, then 11, then 10.
- R12: The edge that samples `rd_i` clears `tsd_flag_o`. The flag sets again if any thermal input is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | NUM_CH | Local transmit input per channel, 0 = dominant |
| bus_i | input | NUM_CH | Sampled bus level per channel, 0 = dominant |
| tsd_i | input | NUM_CH | Thermal shutdown per channel, active high |
| uv_i | input | NUM_CH | Supply undervoltage per channel, active high |
| mode_i | input | 2*NUM_CH | Mode per channel: 00 off, 01 wake-capable, 1x normal |
| rd_i | input | 1 | Status read strobe, clear-on-read |
| status_o | output | 2*NUM_CH+2 | Packed latched fault codes |
| tsd_flag_o | output | 1 | Latched global thermal shutdown flag |
| tx_en_o | output | NUM_CH | Transmitter enable per channel, 0 = forced recessive |

## Verification
A corrupted dominant-time counter shows up at `tx_en_o` as a fall that comes one or more cycles too early or too late against the configured timeout. The bench checks the edge just before the limit and the edge at the limit. A recovery counter that does not restart on a low pulse, or that counts from the wrong edge, changes the cycle on which `tx_en_o` rises again. That cycle is sampled exactly. A latch error appears in `status_o` within one cycle: a code that moves once latched, a read that fails to clear, or a persistent fault that is not latched again at the edge after the read.

// File: rtl/lin_sup_pkg.sv
package lin_sup_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_TSD  = 2'b01,
    FC_TXD  = 2'b10,
    FC_BUS  = 2'b11
  } fault_code_e;

  // mode bit 1 set = normal (transmitting) mode
  function automatic logic mode_is_normal(input logic [1:0] mode);
    return mode[1];
  endfunction

  // thermal > bus dominant > txd dominant
  function automatic fault_code_e pick_fault(input logic tsd, input logic bus_to,
                                             input logic txd_to);
    if (tsd)         return FC_TSD;
    else if (bus_to) return FC_BUS;
    else if (txd_to) return FC_TXD;
    else             return FC_NONE;
  endfunction

endpackage

// File: rtl/lin_dom_timer.sv
module lin_dom_timer #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dom_i,
  output logic to_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (to_q) begin
      cnt_q <= '0;
      if (!dom_i || !arm_i) to_q <= 1'b0;
    end else if (arm_i && dom_i) begin
      if (cnt_q == CW'(LIMIT - 1)) begin
        to_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign to_o = to_q;

  // R3 / R4: a timeout only trips on an armed dominant sample
  assert_trip_needs_dom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> $past(dom_i && arm_i));

  // R6 / R7: recessive level or disarm releases the timeout
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && (!dom_i || !arm_i)) |=> !to_q);

endmodule

// File: rtl/lin_tx_recovery.sv
module lin_tx_recovery #(
  parameter int unsigned EN_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic txd_i,
  output logic tx_en_o
);
  localparam int unsigned CW = (EN_CYC < 2) ? 1 : $clog2(EN_CYC);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fault_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (!txd_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(EN_CYC - 1)) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tx_en_o = !fault_i && !pend_q;

  // R9: re-enable only on a recessive transmit sample
  assert_en_after_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(txd_i));

  // R9: a low transmit input keeps a pending channel disabled
  assert_low_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !txd_i) |=> !tx_en_o);

endmodule

// File: rtl/lin_fault_latch.sv
module lin_fault_latch
  import lin_sup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  fault_code_e ev_i,
  output logic [1:0]  code_o
);
  fault_code_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             code_q <= FC_NONE;
    else if (rd_i)                           code_q <= FC_NONE;
    else if (code_q == FC_NONE && ev_i != FC_NONE) code_q <= ev_i;
  end

  assign code_o = code_q;

  // R11: first code held until read
  assert_code_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != FC_NONE && !rd_i) |=> $stable(code_q));

  // R10: read clears
  assert_read_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (code_q == FC_NONE));

endmodule

// File: rtl/lin_tx_supervisor.sv
module lin_tx_supervisor
  import lin_sup_pkg::*;
#(
  parameter int unsigned NUM_CH     = 3,
  parameter int unsigned TXD_TO_CYC = 2000,
  parameter int unsigned BUS_TO_CYC = 2000,
  parameter int unsigned TXD_EN_CYC = 100
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     txd_i,
  input  logic [NUM_CH-1:0]     bus_i,
  input  logic [NUM_CH-1:0]     tsd_i,
  input  logic [NUM_CH-1:0]     uv_i,
  input  logic [2*NUM_CH-1:0]   mode_i,
  input  logic                  rd_i,
  output logic [2*NUM_CH+1:0]   status_o,
  output logic                  tsd_flag_o,
  output logic [NUM_CH-1:0]     tx_en_o
);
  localparam int unsigned STAT_W = 2 * NUM_CH + 2;

  logic [2*NUM_CH-1:0] code_w;
  logic                tsd_flag_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic        arm;
    logic        txd_to;
    logic        bus_to;
    logic        fault;
    fault_code_e ev;

    assign arm   = mode_is_normal(mode_i[2*k +: 2]);
    assign fault = tsd_i[k] | uv_i[k] | txd_to | bus_to;
    assign ev    = pick_fault(tsd_i[k], bus_to, txd_to);

    lin_dom_timer #(.LIMIT(TXD_TO_CYC)) u_txd_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm),
      .dom_i  (!txd_i[k]),
      .to_o   (txd_to)
    );

    lin_dom_timer #(.LIMIT(BUS_TO_CYC)) u_bus_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm),
      .dom_i  (!bus_i[k]),
      .to_o   (bus_to)
    );

    lin_tx_recovery #(.EN_CYC(TXD_EN_CYC)) u_rec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fault_i (fault),
      .txd_i   (txd_i[k]),
      .tx_en_o (tx_en_o[k])
    );

    lin_fault_latch u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rd_i   (rd_i),
      .ev_i   (ev),
      .code_o (code_w[2*k +: 2])
    );

    // R5: thermal input gates transmitter in the same cycle
    assert_tsd_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tsd_i[k] |-> !tx_en_o[k]);

    // R8: undervoltage gates transmitter and latches no code of its own
    assert_uv_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_i[k] |-> !tx_en_o[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tsd_flag_q <= 1'b0;
    else if (rd_i)   tsd_flag_q <= 1'b0;
    else if (|tsd_i) tsd_flag_q <= 1'b1;
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_W-2:1] = code_w;
  end

  assign tsd_flag_o = tsd_flag_q;

  // R12: global flag only rises from a channel thermal input
  assert_tsd_flag_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsd_flag_q) |-> $past(|tsd_i));

endmodule

// File: tb/lin_tx_supervisor_tb.sv
module lin_tx_supervisor_tb;
  localparam int NCH = 3;
  localparam int TXD = 20;
  localparam int BUS = 30;
  localparam int TEN = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] txd = '1, bus = '1, tsd = '0, uv = '0;
  logic [2*NCH-1:0] mode = 6'b10_10_10;
  logic           rd = 1'b0;
  logic [2*NCH+1:0] status;
  logic           tsd_flag;
  logic [NCH-1:0] tx_en;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lin_tx_supervisor #(
    .NUM_CH(NCH), .TXD_TO_CYC(TXD), .BUS_TO_CYC(BUS), .TXD_EN_CYC(TEN)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .txd_i(txd), .bus_i(bus), .tsd_i(tsd),
    .uv_i(uv), .mode_i(mode), .rd_i(rd), .status_o(status),
    .tsd_flag_o(tsd_flag), .tx_en_o(tx_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_read();
    rd = 1'b1;
    tick(1);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    tick(2);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 reset status", status, 0);
    chk("R1 reset tx_en", tx_en, 3'b111);
    chk("R1 reset tsd flag", tsd_flag, 0);
  endtask

  task automatic t_txd_timeout();
    txd[0] = 1'b0;
    tick(TXD - 1);
    chk("R3 no trip before limit", tx_en[0], 1);
    tick(1);
    chk("R3 trip at limit", tx_en[0], 0);
    tick(1);
    chk("R3 R2 code 10", status[2:1], 2);
    rd = 1'b1;
    #1;
    chk("R10 read shows code", status[2:1], 2);
    tick(1);
    rd = 1'b0;
    chk("R10 cleared by read", status, 0);
    tick(1);
    chk("R10 persistent relatch", status[2:1], 2);
    txd[0] = 1'b1;
    tick(TEN);
    chk("R9 still disabled", tx_en[0], 0);
    tick(1);
    chk("R6 R9 re-enabled", tx_en[0], 1);
    do_read();
    chk("R10 clear after recovery", status, 0);
  endtask

  task automatic t_bus_timeout();
    bus[2] = 1'b0;
    tick(BUS - 1);
    chk("R4 no trip before limit", tx_en[2], 1);
    tick(1);
    chk("R4 trip at limit", tx_en[2], 0);
    tick(1);
    chk("R1 R4 field 6:5 = 11", status, 8'b0110_0000);
    bus[2] = 1'b1;
    tick(TEN);
    chk("R7 still disabled", tx_en[2], 0);
    tick(1);
    chk("R7 re-enabled", tx_en[2], 1);
    do_read();
  endtask

  task automatic t_txd_mode_recover();
    txd[1] = 1'b0;
    tick(TXD + 1);
    chk("R1 R3 field 4:3 = 10", status, 8'b0001_0000);
    mode[3:2] = 2'b01;
    tick(2);
    do_read();
    tick(3);
    chk("R6 wake mode cleared timeout", status, 0);
    chk("R9 low txd keeps disabled", tx_en[1], 0);
    txd[1] = 1'b1;
    mode[3:2] = 2'b10;
    tick(TEN - 1);
    chk("R9 not yet", tx_en[1], 0);
    tick(1);
    chk("R9 enabled after window", tx_en[1], 1);
  endtask

  task automatic t_restart();
    txd[1] = 1'b0;
    tick(TXD);
    chk("R3 tripped", tx_en[1], 0);
    txd[1] = 1'b1;
    tick(5);
    chk("R9 partial window", tx_en[1], 0);
    txd[1] = 1'b0;
    tick(1);
    txd[1] = 1'b1;
    tick(TEN - 1);
    chk("R9 low pulse restarted count", tx_en[1], 0);
    tick(1);
    chk("R9 enabled after full window", tx_en[1], 1);
    do_read();
  endtask

  task automatic t_thermal();
    tsd[1] = 1'b1;
    #1;
    chk("R5 same-cycle gate", tx_en[1], 0);
    tick(1);
    chk("R5 R2 code 01", status[4:3], 1);
    chk("R5 global flag", tsd_flag, 1);
    tsd[1] = 1'b0;
    tick(TEN - 1);
    chk("R9 after thermal not yet", tx_en[1], 0);
    tick(1);
    chk("R9 after thermal enabled", tx_en[1], 1);
    do_read();
    chk("R12 flag cleared by read", tsd_flag, 0);
    chk("R10 code cleared", status, 0);
  endtask

  task automatic t_first_hold();
    txd[0] = 1'b0;
    tick(TXD + 1);
    chk("R3 code 10", status[2:1], 2);
    tsd[0] = 1'b1;
    tick(2);
    chk("R11 first code held", status[2:1], 2);
    chk("R5 flag despite held code", tsd_flag, 1);
    do_read();
    tick(1);
    chk("R12 flag relatched while hot", tsd_flag, 1);
    tsd[0] = 1'b0;
    txd[0] = 1'b1;
    do_read();
    tick(TEN + 2);
    chk("R11 cleared", status, 0);
    chk("R12 flag cleared", tsd_flag, 0);
    chk("R9 channel 0 back", tx_en[0], 1);
  endtask

  task automatic t_priority();
    bus[2] = 1'b0;
    tick(BUS - TXD);
    txd[2] = 1'b0;
    tick(TXD);
    chk("R4 tripped", tx_en[2], 0);
    tick(1);
    chk("R11 bus beats txd", status[6:5], 3);
    bus[2] = 1'b1;
    txd[2] = 1'b1;
    tick(TEN + 2);
    do_read();
    chk("R11 cleared", status, 0);
    chk("R9 channel 2 back", tx_en[2], 1);
  endtask

  task automatic t_uv();
    uv[0] = 1'b1;
    #1;
    chk("R8 same-cycle gate", tx_en[0], 0);
    tick(5);
    chk("R8 no code", status, 0);
    chk("R8 held low", tx_en[0], 0);
    uv[0] = 1'b0;
    tick(TEN - 1);
    chk("R8 not yet", tx_en[0], 0);
    tick(1);
    chk("R8 recovered", tx_en[0], 1);
  endtask

  task automatic t_bus_mode_recover();
    bus[0] = 1'b0;
    tick(BUS + 1);
    chk("R4 code 11 ch0", status[2:1], 3);
    mode[1:0] = 2'b00;
    tick(2);
    do_read();
    tick(2);
    chk("R7 off mode cleared timeout", status, 0);
    bus[0] = 1'b1;
    mode[1:0] = 2'b10;
    tick(TEN + 1);
    chk("R7 channel 0 back", tx_en[0], 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_txd_timeout();
    t_bus_timeout();
    t_txd_mode_recover();
    t_restart();
    t_thermal();
    t_first_hold();
    t_priority();
    t_uv();
    t_bus_mode_recover();
    tick(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

endmodule